// File: doc/BRIEF.md
# Scan-line timing core with line-compare interrupt

This block keeps the vertical timing of a display controller. A clock counter divides the system clock into scan lines of a fixed length. A line counter steps once per scan line and wraps at the end of each frame. The current line number and a flag for the top line leave the block as outputs, so the rest of the display pipeline can use them.

Software programs a 9-bit target line through a byte-wide register bus. The top bit of the target sits in one register and the low byte in another. Each time the line counter steps onto the target line, the block latches an event in a status register. If the line interrupt is enabled, it also raises a request that stays up until software acknowledges it. The register set is decoded from the low six address bits, so it repeats throughout the address window given to the block.

Top module: `scanline_irq_core`

## Requirements
- R1: The line counter advances by one exactly once every 63 clocks. The clock counter restarts at 0 after reaching 62, and the line steps on that same edge.
- R2: A frame holds 312 lines. The line after 311 is 0.
- R3: `vsync_o` is high during exactly the cycles in which `line_o` is 0.
- R4: Bit 7 written to offset 0x11 sets target bit 8, and a write to offset 0x12 sets target bits 7..0. Reading 0x11 returns target bit 8 in bit 7 with zeros in the other bits. Reading 0x12 returns the low byte.
- R5: The status register sits at offset 0x19. When the line steps onto the target, bit 0 (line event) and bit 7 (any event) are both set. When the line steps onto any other line, bit 0 clears and bit 7 keeps its value. Bits 6..1 read 0.
- R6: A match raises `irq_o` only if bit 0 of the enable register (offset 0x1A) was set at the moment of the match. A match taken while that bit is clear does not raise the request, even if the bit is set afterwards. `irq_o` is never high while that bit is clear.
- R7: After reset, the line is 1, the clock counter is 0, the target is 0, the status register is 0, the enable register is 0 and `irq_o` is low.
- R8: Only address bits 5..0 select a register. An access at offset + 0x40·k reaches the same register as the offset itself.
- R9: Writing 1 to status bit 0 clears it, and writing 1 to status bit 7 clears bit 7 and withdraws a pending request. Writing 0 to a bit leaves it unchanged. While a request is pending and enabled, `irq_o` stays high until it is acknowledged. If a match and an acknowledge land on the same edge, the match wins.
- R10: Offsets outside 0x11, 0x12, 0x19 and 0x1A read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 10 | Register address; only bits 5..0 are decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register selected by `bus_addr` |
| line_o | output | 9 | Current scan line |
| vsync_o | output | 1 | High while the current line is 0 |
| irq_o | output | 1 | Line-compare interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- the clock counter stays in range and steps by one;
- the line holds between steps and wraps from 311 to 0;
- the line event bit never rises without the summary bit, and never outside a line step;
- the request is never up without its enable;
- the request never drops without a bus write.

Other behaviours need the bench's scenarios:
- that a match lands on the right line for each split of the target across the two registers;
- that a match taken while disabled stays silent after a later enable;
- that mirrored addresses reach the same registers;
- that unmapped offsets leave the state untouched.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  // Register offsets inside the 64-byte decode window
  localparam int unsigned SEL_W = 6;
  localparam logic [SEL_W-1:0] OFS_TGT_HI = 6'h11;
  localparam logic [SEL_W-1:0] OFS_TGT_LO = 6'h12;
  localparam logic [SEL_W-1:0] OFS_STAT   = 6'h19;
  localparam logic [SEL_W-1:0] OFS_ENA    = 6'h1A;

  // Status bit positions
  localparam int unsigned STAT_LINE_BIT = 0;
  localparam int unsigned STAT_ANY_BIT  = 7;

  typedef struct packed {
    logic             wr;
    logic [SEL_W-1:0] sel;
    logic [7:0]       data;
  } reg_wr_t;
endpackage

// File: rtl/scanline_clk_ctr.sv
module scanline_clk_ctr #(
  parameter int unsigned CLKS_PER_LINE = 63
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap_o
);
  localparam int unsigned CW = $clog2(CLKS_PER_LINE);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_LINE - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    wrap_o = (cnt_q == LAST);
    cnt_d  = wrap_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_cnt_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/scanline_line_ctr.sv
module scanline_line_ctr #(
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned RESET_LINE      = 1,
  parameter int unsigned LW              = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  output logic [LW-1:0] line_o,
  output logic [LW-1:0] line_nxt_o
);
  localparam logic [LW-1:0] LAST  = LW'(LINES_PER_FRAME - 1);
  localparam logic [LW-1:0] START = LW'(RESET_LINE);

  logic [LW-1:0] line_q;
  logic [LW-1:0] line_d;

  always_comb begin
    line_nxt_o = (line_q == LAST) ? '0 : line_q + 1'b1;
    line_d     = line_q;
    if (step_i) line_d = line_nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= START;
    else        line_q <= line_d;
  end

  assign line_o = line_q;

  assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(line_q));
  assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LAST);
  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && line_q == LAST) |=> (line_q == '0));
endmodule

// File: rtl/scanline_regs.sv
module scanline_regs
  import scanline_pkg::*;
#(
  parameter int unsigned LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  reg_wr_t       wr_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [7:0]    rdata_o,
  input  logic          step_i,
  input  logic [LW-1:0] line_nxt_i,
  output logic          irq_o
);
  localparam int unsigned HI_W = LW - 8;

  logic [LW-1:0] tgt_q, tgt_d;
  logic          evt_q, evt_d;
  logic          any_q, any_d;
  logic          ena_q, ena_d;
  logic          pend_q, pend_d;

  logic wr_hi, wr_lo, wr_stat, wr_ena;
  logic clr_evt, clr_any, hit;

  // next-state
  always_comb begin
    wr_hi   = wr_i.wr && (wr_i.sel == OFS_TGT_HI);
    wr_lo   = wr_i.wr && (wr_i.sel == OFS_TGT_LO);
    wr_stat = wr_i.wr && (wr_i.sel == OFS_STAT);
    wr_ena  = wr_i.wr && (wr_i.sel == OFS_ENA);
    clr_evt = wr_stat && wr_i.data[STAT_LINE_BIT];
    clr_any = wr_stat && wr_i.data[STAT_ANY_BIT];
    hit     = step_i && (line_nxt_i == tgt_q);

    tgt_d = tgt_q;
    if (wr_hi) tgt_d[LW-1 -: HI_W] = wr_i.data[7 -: HI_W];
    if (wr_lo) tgt_d[7:0]          = wr_i.data;

    ena_d = wr_ena ? wr_i.data[0] : ena_q;

    if (step_i) evt_d = hit;
    else        evt_d = evt_q && !clr_evt;

    any_d  = hit || (any_q && !clr_any);
    pend_d = (hit && ena_q) || (pend_q && !clr_any);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      evt_q  <= 1'b0;
      any_q  <= 1'b0;
      ena_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      evt_q  <= evt_d;
      any_q  <= any_d;
      ena_q  <= ena_d;
      pend_q <= pend_d;
    end
  end

  assign irq_o = pend_q && ena_q;

  // read path
  always_comb begin
    rdata_o = '0;
    case (rd_sel_i)
      OFS_TGT_HI: rdata_o[7 -: HI_W] = tgt_q[LW-1 -: HI_W];
      OFS_TGT_LO: rdata_o = tgt_q[7:0];
      OFS_STAT: begin
        rdata_o[STAT_LINE_BIT] = evt_q;
        rdata_o[STAT_ANY_BIT]  = any_q;
      end
      OFS_ENA:    rdata_o[0] = ena_q;
      default:    rdata_o = '0;
    endcase
  end

  assert_evt_with_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> any_q);
  assert_evt_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(step_i));
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ena_q);
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_i.wr) |=> irq_o);
endmodule

// File: rtl/scanline_irq_core.sv
module scanline_irq_core
  import scanline_pkg::*;
#(
  parameter int unsigned CLKS_PER_LINE   = 63,
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned RESET_LINE      = 1,
  parameter int unsigned LINE_W          = 9,
  parameter int unsigned ADDR_W          = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [LINE_W-1:0] line_o,
  output logic              vsync_o,
  output logic              irq_o
);
  logic              line_step;
  logic [LINE_W-1:0] line_nxt;
  reg_wr_t           wr_req;
  logic              unused_addr_hi;

  assign wr_req.wr   = bus_wr;
  assign wr_req.sel  = bus_addr[SEL_W-1:0];
  assign wr_req.data = bus_wdata;
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:SEL_W];

  scanline_clk_ctr #(.CLKS_PER_LINE(CLKS_PER_LINE)) u_clk_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_o (line_step)
  );

  scanline_line_ctr #(
    .LINES_PER_FRAME (LINES_PER_FRAME),
    .RESET_LINE      (RESET_LINE),
    .LW              (LINE_W)
  ) u_line_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (line_step),
    .line_o     (line_o),
    .line_nxt_o (line_nxt)
  );

  scanline_regs #(.LW(LINE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_req),
    .rd_sel_i   (bus_addr[SEL_W-1:0]),
    .rdata_o    (bus_rdata),
    .step_i     (line_step),
    .line_nxt_i (line_nxt),
    .irq_o      (irq_o)
  );

  assign vsync_o = (line_o == '0);

  assert_vsync_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_o) |-> (line_o == LINE_W'(1)));
endmodule

// File: tb/scanline_irq_core_test.sv
module scanline_irq_core_test;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic [9:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [8:0] line_o;
  logic       vsync_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  scanline_irq_core uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_o(line_o),
    .vsync_o(vsync_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { int line; int vs; int irq; } exp_t;
  exp_t exp_q[$];

  // requirement model state
  int m_dot, m_line, m_tgt, m_evt, m_any, m_ena, m_pend;

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver side: model steps every edge and pushes the expected outputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_dot = 0; m_line = 1; m_tgt = 0; m_evt = 0; m_any = 0; m_ena = 0; m_pend = 0;
    end else begin
      int  old_tgt, old_ena, nl;
      bit  step, hit, c0, c7;
      old_tgt = m_tgt; old_ena = m_ena;
      step = (m_dot == 62);
      nl   = (m_line == 311) ? 0 : m_line + 1;
      hit  = step && (nl == old_tgt);
      c0   = bus_wr && bus_addr[5:0] == 6'h19 && bus_wdata[0];
      c7   = bus_wr && bus_addr[5:0] == 6'h19 && bus_wdata[7];
      if (bus_wr) begin
        case (bus_addr[5:0])
          6'h11: m_tgt = (m_tgt & 255) | (bus_wdata[7] ? 256 : 0);
          6'h12: m_tgt = (m_tgt & 256) | int'(bus_wdata);
          6'h1A: m_ena = int'(bus_wdata[0]);
          default: ;
        endcase
      end
      m_evt  = step ? int'(hit) : (m_evt & int'(!c0));
      m_any  = int'(hit) | (m_any & int'(!c7));
      m_pend = (int'(hit) & old_ena) | (m_pend & int'(!c7));
      if (step) begin m_dot = 0; m_line = nl; end
      else m_dot = m_dot + 1;
    end
    exp_q.push_back('{m_line, int'(m_line == 0), m_pend & m_ena});
  end

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R1", int'(line_o), e.line, "line (R2 wrap)");
      chk("R3", int'(vsync_o), e.vs, "vsync");
      chk("R6", int'(irq_o), e.irq, "irq (R9 hold)");
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=%0d expected<=150000 cycles", cyc);
      summary();
    end
  end

  task automatic wr(int addr, int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'(addr); bus_wdata = 8'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int addr, int exp, string req);
    @(negedge clk);
    bus_addr = 10'(addr);
    #1;
    chk(req, int'(bus_rdata), exp, $sformatf("read 0x%0h", addr));
  endtask

  task automatic wait_line(int n);
    while (m_line != n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7", int'(line_o), 1, "line after reset");
    chk("R7", int'(irq_o), 0, "irq after reset");
    rd(10'h11, 0, "R7"); rd(10'h12, 0, "R7"); rd(10'h19, 0, "R7"); rd(10'h1A, 0, "R7");
    @(negedge clk) rst_n = 1'b1;

    // enabled match on line 5
    wr(10'h1A, 8'h01);
    wr(10'h12, 5);
    rd(10'h12, 5, "R4");
    wait_line(5);
    rd(10'h19, 8'h81, "R5");
    chk("R6", int'(irq_o), 1, "irq on enabled match");
    wait_line(6);
    rd(10'h19, 8'h80, "R5");
    wr(10'h19, 8'h00);
    rd(10'h19, 8'h80, "R9");
    chk("R9", int'(irq_o), 1, "irq held until ack");
    wr(10'h19, 8'h80);
    rd(10'h19, 8'h00, "R9");
    chk("R9", int'(irq_o), 0, "irq after ack");

    // mirrored decode and disabled match
    wr(10'h3D2, 10);
    rd(10'h052, 10, "R8");
    wr(10'h05A, 8'h00);
    rd(10'h1A, 0, "R8");
    wait_line(10);
    rd(10'h19, 8'h81, "R5");
    chk("R6", int'(irq_o), 0, "disabled match");
    wr(10'h1A, 8'h01);
    @(negedge clk);
    chk("R6", int'(irq_o), 0, "late enable stays silent");
    wr(10'h2D9, 8'h81);
    rd(10'h19, 8'h00, "R9");

    // nine-bit target 300
    wr(10'h11, 8'hFF);
    wr(10'h12, 8'h2C);
    rd(10'h11, 8'h80, "R4");
    rd(10'h12, 8'h2C, "R4");
    wait_line(300);
    rd(10'h19, 8'h81, "R4");
    chk("R6", int'(irq_o), 1, "irq at line 300");
    wr(10'h19, 8'h80);
    rd(10'h19, 8'h01, "R9");
    wr(10'h19, 8'h01);
    rd(10'h19, 8'h00, "R9");

    // unmapped offsets
    wr(10'h20, 8'hFF);
    wr(10'h13, 8'hFF);
    rd(10'h20, 0, "R10");
    rd(10'h13, 0, "R10");
    rd(10'h12, 8'h2C, "R10");
    rd(10'h1A, 1, "R10");
    rd(10'h19, 0, "R10");

    // target 0: frame wrap
    wr(10'h11, 8'h00);
    wr(10'h12, 8'h00);
    wait_line(311);
    chk("R2", int'(vsync_o), 0, "vsync on last line");
    wait_line(0);
    chk("R3", int'(vsync_o), 1, "vsync on line 0");
    rd(10'h19, 8'h81, "R2");
    wr(10'h19, 8'h81);
    wait_line(1);
    chk("R3", int'(vsync_o), 0, "vsync after line 0");
    rd(10'h19, 8'h00, "R5");
    repeat (5) @(negedge clk);
    summary();
  end
endmodule